// File: doc/BRIEF.md
# Two-Symbol Sequence Driven Moore Flag

This block watches a stream of 2-bit symbols, formed from two single-bit inputs `x1` (upper bit) and `x2` (lower bit). It takes one symbol on each clock where the enable strobe is high. It keeps a single registered flag `z`. The flag holds its value until a two-symbol pattern completes. Every pattern ends with the symbol 11, and the symbol taken just before that 11 decides the outcome: 00 clears the flag, 01 sets it, and 10 inverts it.

The machine is of Moore type, so `z` comes from the state register alone. A completing 11 affects the flag only on the clock edge that samples it. Only the two most recent enabled samples count. A prefix followed by anything other than 11 is dropped, and that new symbol becomes the candidate prefix. The register contents appear on `seq_state`, so a test environment can see the pending prefix next to the flag.

Top module: `pair_seq_moore`

## Requirements
- R1: A rising clock edge with `rst` high sets `seq_state` to 3'b000, which means no pending prefix and `z` = 0. `seq_state[2:1]` holds the pending prefix code (0 none, 1 after 00, 2 after 01, 3 after 10) and `seq_state[0]` is `z`.
- R2: On an edge where `en` is low, `seq_state` and `z` do not change, whatever `x1`/`x2` carry.
- R3: An enabled symbol other than 11 leaves `z` unchanged. It sets the pending code to the symbol value plus one: 00 gives 1, 01 gives 2, 10 gives 3.
- R4: An enabled 11 with pending code 1 (prefix 00) drives `z` to 0 on that edge.
- R5: An enabled 11 with pending code 2 (prefix 01) drives `z` to 1 on that edge.
- R6: An enabled 11 with pending code 3 (prefix 10) inverts `z` on that edge. This holds from both 0 and 1.
- R7: An enabled 11 with no pending prefix leaves `z` unchanged. After any enabled 11 the pending code is 0, so a second 11 does nothing.
- R8: A pending prefix followed by another non-11 symbol is replaced by that symbol, including a repeat of the same prefix. The next 11 then acts on the last prefix only.
- R9: `z` equals `seq_state[0]` at all times. It changes only on the edge that samples an enabled 11, and never before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample strobe; symbol taken when high |
| x1 | input | 1 | Upper bit of the symbol |
| x2 | input | 1 | Lower bit of the symbol |
| z | output | 1 | Registered flag |
| seq_state | output | 3 | {pending prefix code, z} |

## Verification
The properties check on every cycle that a disabled edge freezes the state. They also check that a non-terminating symbol records its prefix code without touching the flag, that each of the three outcomes follows the pending code, that a bare 11 has no effect, and that reset clears everything. Only the bench scenarios can show that a chain of prefixes resolves to the last one across several symbols, with enable gaps placed between prefix and terminator. They also show that toggling works from both flag values over long mixed streams, and that a reset in mid-stream drops a pending prefix.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int SYM_W  = 2;
    localparam int PEND_W = 2;
    localparam int STATE_W = PEND_W + 1;

    typedef enum logic [PEND_W-1:0] {
        PEND_NONE = 2'd0,
        PEND_CLR  = 2'd1,
        PEND_SET  = 2'd2,
        PEND_TOG  = 2'd3
    } pend_e;

    typedef struct packed {
        pend_e pend;
        logic  z;
    } seq_state_t;

endpackage

// File: rtl/seq_sym_decode.sv
module seq_sym_decode
    import seq_pkg::*;
#(
    parameter logic [SYM_W-1:0] CLR_SYM = 2'b00,
    parameter logic [SYM_W-1:0] SET_SYM = 2'b01,
    parameter logic [SYM_W-1:0] TOG_SYM = 2'b10,
    parameter logic [SYM_W-1:0] END_SYM = 2'b11
) (
    input  logic [SYM_W-1:0] sym,
    output logic             is_end,
    output pend_e            kind
);

    always_comb begin
        is_end = (sym == END_SYM);
        if (sym == CLR_SYM)      kind = PEND_CLR;
        else if (sym == SET_SYM) kind = PEND_SET;
        else if (sym == TOG_SYM) kind = PEND_TOG;
        else                     kind = PEND_NONE;
    end

endmodule

// File: rtl/seq_outcome.sv
module seq_outcome
    import seq_pkg::*;
(
    input  pend_e pend,
    input  logic  z_now,
    output logic  z_next
);

    always_comb begin
        unique case (pend)
            PEND_CLR: z_next = 1'b0;
            PEND_SET: z_next = 1'b1;
            PEND_TOG: z_next = ~z_now;
            default:  z_next = z_now;
        endcase
    end

endmodule

// File: rtl/pair_seq_moore.sv
module pair_seq_moore
    import seq_pkg::*;
#(
    parameter logic [SYM_W-1:0] CLR_SYM = 2'b00,
    parameter logic [SYM_W-1:0] SET_SYM = 2'b01,
    parameter logic [SYM_W-1:0] TOG_SYM = 2'b10,
    parameter logic [SYM_W-1:0] END_SYM = 2'b11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               x1,
    input  logic               x2,
    output logic               z,
    output logic [STATE_W-1:0] seq_state
);

    seq_state_t st_d, st_q;
    logic       sym_end;
    pend_e      sym_kind;
    logic       z_res;

    seq_sym_decode #(
        .CLR_SYM(CLR_SYM),
        .SET_SYM(SET_SYM),
        .TOG_SYM(TOG_SYM),
        .END_SYM(END_SYM)
    ) u_decode (
        .sym    ({x1, x2}),
        .is_end (sym_end),
        .kind   (sym_kind)
    );

    seq_outcome u_outcome (
        .pend   (st_q.pend),
        .z_now  (st_q.z),
        .z_next (z_res)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (sym_end) begin
                st_d.z    = z_res;
                st_d.pend = PEND_NONE;
            end else begin
                st_d.pend = sym_kind;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pend: PEND_NONE, z: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign z         = st_q.z;
    assign seq_state = st_q;

endmodule

// File: rtl/pair_seq_moore_chk.sv
module pair_seq_moore_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       x1,
    input logic       x2,
    input logic       z,
    input logic [2:0] seq_state
);

    logic end_sym;
    assign end_sym = en && x1 && x2;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (seq_state == 3'b000));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(seq_state));

    assert_prefix_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !(x1 && x2)) |=> ($stable(z) && (seq_state[2:1] == $past({x1, x2}) + 2'd1)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (end_sym && seq_state[2:1] == 2'd1) |=> !z);

    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        (end_sym && seq_state[2:1] == 2'd2) |=> z);

    assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (end_sym && seq_state[2:1] == 2'd3) |=> (z != $past(z)));

    assert_bare_end_R7: assert property (@(posedge clk) disable iff (rst)
        (end_sym && seq_state[2:1] == 2'd0) |=> $stable(z));

    assert_clear_pend_R7: assert property (@(posedge clk) disable iff (rst)
        end_sym |=> (seq_state[2:1] == 2'd0));

    assert_only_on_end_R9: assert property (@(posedge clk) disable iff (rst)
        !end_sym |=> $stable(z));

endmodule

bind pair_seq_moore pair_seq_moore_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .x1        (x1),
    .x2        (x2),
    .z         (z),
    .seq_state (seq_state)
);

// File: tb/pair_seq_moore_bench.sv
module pair_seq_moore_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       x1  = 1'b0;
    logic       x2  = 1'b0;
    logic       z;
    logic [2:0] seq_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0] m_pend = 2'd0;
    logic       m_z    = 1'b0;

    always #5 clk = ~clk;

    pair_seq_moore u_pair_seq_moore (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .x1        (x1),
        .x2        (x2),
        .z         (z),
        .seq_state (seq_state)
    );

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        x1  = 1'b0;
        x2  = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R1", seq_state, 3'b000);
        chk("R1", {2'b00, z}, 3'b000);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        m_pend = 2'd0;
        m_z    = 1'b0;
    endtask

    task automatic step(input logic e, input logic [1:0] s);
        string tag;
        logic  z_before;
        z_before = m_z;
        if (!e) begin
            tag = "R2";
        end else if (s == 2'b11) begin
            case (m_pend)
                2'd1:    begin tag = "R4"; m_z = 1'b0; end
                2'd2:    begin tag = "R5"; m_z = 1'b1; end
                2'd3:    begin tag = "R6"; m_z = ~m_z; end
                default: tag = "R7";
            endcase
            m_pend = 2'd0;
        end else begin
            tag = (m_pend != 2'd0) ? "R8" : "R3";
            m_pend = s + 2'd1;
        end
        @(negedge clk);
        en = e;
        {x1, x2} = s;
        #1;
        chk("R9", {2'b00, z}, {2'b00, z_before});
        @(posedge clk);
        #1;
        chk(tag, seq_state, {m_pend, m_z});
        chk("R9", {2'b00, z}, {2'b00, seq_state[0]});
    endtask

    initial begin
        logic [15:0] lfsr;
        do_reset();

        for (int z0 = 0; z0 < 2; z0++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int c = 0; c < 4; c++) begin
                        step(1'b1, (z0 == 1) ? 2'b01 : 2'b00);
                        step(1'b1, 2'b11);
                        step(1'b1, a[1:0]);
                        step(1'b1, b[1:0]);
                        step(1'b0, ~b[1:0]);
                        step(1'b1, c[1:0]);
                    end
                end
            end
        end

        step(1'b1, 2'b10);
        step(1'b1, 2'b11);
        step(1'b1, 2'b10);
        step(1'b1, 2'b11);
        step(1'b1, 2'b11);
        step(1'b1, 2'b00);
        step(1'b1, 2'b00);
        step(1'b1, 2'b00);
        step(1'b1, 2'b11);

        step(1'b1, 2'b01);
        do_reset();
        step(1'b1, 2'b11);

        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2] | lfsr[5], lfsr[1:0]);
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule